// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block runs the external memory bus of a small 8-bit controller core. It counts oscillator periods through a divide-by-two stage. Two oscillator periods make one state, and a machine cycle is a fixed number of states, six by default, which gives 12 oscillator periods. In every machine cycle it produces the address latch pulse, the active-low program-store strobe and the active-low data read and write strobes. It places the low address byte and then the data byte on a multiplexed low port, and it places a high byte on a second port.

The core raises a code-fetch request or a data request, with flags for write and for 16-bit pointer addressing. The block samples these requests at the last oscillator period of a machine cycle and reports acceptance with `req_taken`. The accepted request then runs during the next machine cycle. When no request is pending, the low port acts as an open-drain port and the high port shows its register value. Fetched code bytes and read data are returned with one-cycle valid pulses.

Top module: `bus_strobe_seq`

## Requirements
- R1: ALE pulses high for exactly 2 oscillator periods, at the start of each half machine cycle. In idle and code cycles this gives 2 pulses per 12-period machine cycle, so 4 rising edges in any 24 consecutive periods.
- R2: A machine cycle that runs a data access (read or write) has exactly one ALE pulse, the one at its start. The mid-cycle pulse is dropped.
- R3: A code cycle at address A makes two `psen_n` low pulses of 3 periods each, one in each half. They fetch A and then A+1. `code_byte` takes the low-port input at each rising edge of `psen_n`, with `code_valid` high for one period.
- R4: A data cycle makes no `psen_n` pulse, and at most one of `psen_n`, `rd_n` and `wr_n` is low at any time.
- R5: While ALE is high and for one period after it falls, the low port drives the low address byte. No read or write strobe is low while ALE is high.
- R6: For code fetches and for 16-bit data accesses, the high port carries the high address byte, with the carry from A to A+1 included. For 8-bit data accesses, the high port carries `p2_sfr`.
- R7: `rd_n` is low for 8 periods. `rd_data` takes the low-port input at the rising edge of `rd_n`, and `rd_valid` pulses for that one period.
- R8: `wr_n` is low for 8 periods. `p0_out` equals the write byte and does not change during the whole time `wr_n` is low.
- R9: While the low port drives an address or write data, all bits of `p0_oe` are 1, so 1s are driven high. While `psen_n` or `rd_n` is low, `p0_oe` is 0.
- R10: Outside bus cycles, `p0_out` equals `p0_sfr` and `p0_oe` equals the bitwise inverse of `p0_sfr`, so a written 1 floats.
- R11: If a data request and a code request are both pending at the sampling point, the data access runs first. The code request is taken at the next sampling point.
- R12: During reset, ALE is 1, all three strobes are 1, `p0_oe` and `p2_oe` are 0, and `req_taken` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| code_req | input | 1 | Request an external code-fetch cycle |
| code_addr | input | 16 | Code fetch address (first of two bytes) |
| data_req | input | 1 | Request an external data cycle |
| data_wr | input | 1 | 1 = write, 0 = read |
| data_wide | input | 1 | 1 = 16-bit pointer, 0 = 8-bit register-indirect |
| data_addr | input | 16 | Data address (only the low byte is used when narrow) |
| wr_data | input | 8 | Write byte |
| p0_sfr | input | 8 | Low-port register value |
| p2_sfr | input | 8 | High-port register value |
| p0_in | input | 8 | Low-port pin input |
| req_taken | output | 1 | Request accepted; its cycle starts now |
| ale | output | 1 | Address latch pulse |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Low-port drive value |
| p0_oe | output | 8 | Low-port per-bit output enable |
| p2_out | output | 8 | High-port drive value |
| p2_oe | output | 1 | High-port output enable |
| code_byte | output | 8 | Fetched code byte |
| code_valid | output | 1 | `code_byte` updated |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | `rd_data` updated |

## Verification
A wrong cycle type or phase counter shows up at the ports within one machine cycle, which is 12 periods. Examples are a second ALE in a data cycle, a program-store pulse that is missing or extra, or a strobe width other than 3 or 8 periods. A wrong latched address or high-byte selection shows up at the first ALE falling edge of the cycle, in the byte that an external latch would capture. Corrupted capture timing shows up in the returned byte at the strobe's rising edge, within the same cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic [1:0] {
    CY_IDLE = 2'd0,
    CY_CODE = 2'd1,
    CY_DRD  = 2'd2,
    CY_DWR  = 2'd3
  } cyc_e;

  // oscillator periods, counted from each half-cycle start
  localparam int ALE_TICKS  = 2;  // latch pulse width
  localparam int ADDR_TICKS = 3;  // address held on the low port
endpackage

// File: rtl/bseq_timebase.sv
module bseq_timebase #(
  parameter  int STATES = 6,
  localparam int SW     = $clog2(STATES),
  localparam int IW     = SW + 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [IW-1:0] idx_nx,
  output logic          wrap
);
  localparam logic [SW-1:0] LAST_ST = SW'(STATES - 1);

  logic          ph_q;
  logic [SW-1:0] st_q;
  logic          ph_nx;
  logic [SW-1:0] st_nx;

  // divide-by-two: a state advances on every second oscillator edge
  always_comb begin
    ph_nx = ~ph_q;
    st_nx = st_q;
    if (ph_q) st_nx = (st_q == LAST_ST) ? '0 : st_q + SW'(1);
  end

  assign idx_nx = {st_nx, ph_nx};
  assign wrap   = ph_q && (st_q == LAST_ST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= 1'b0;
      st_q <= '0;
    end else begin
      ph_q <= ph_nx;
      st_q <= st_nx;
    end
  end
endmodule

// File: rtl/bseq_cycle_ctl.sv
module bseq_cycle_ctl
  import bseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrap,
  input  logic          code_req,
  input  logic [AW-1:0] code_addr,
  input  logic          data_req,
  input  logic          data_wr,
  input  logic          data_wide,
  input  logic [AW-1:0] data_addr,
  input  logic [DW-1:0] wr_data,
  output cyc_e          cyc_nx,
  output logic [AW-1:0] addr_nx,
  output logic          wide_nx,
  output logic [DW-1:0] wdata_nx,
  output logic          req_taken
);
  cyc_e          cyc_q;
  logic [AW-1:0] addr_q;
  logic          wide_q;
  logic [DW-1:0] wdata_q;

  always_comb begin
    cyc_nx   = cyc_q;
    addr_nx  = addr_q;
    wide_nx  = wide_q;
    wdata_nx = wdata_q;
    if (wrap) begin
      if (data_req) begin
        cyc_nx   = data_wr ? CY_DWR : CY_DRD;
        addr_nx  = data_addr;
        wide_nx  = data_wide;
        wdata_nx = wr_data;
      end else if (code_req) begin
        cyc_nx  = CY_CODE;
        addr_nx = code_addr;
        wide_nx = 1'b1;
      end else begin
        cyc_nx = CY_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q     <= CY_IDLE;
      addr_q    <= '0;
      wide_q    <= 1'b0;
      wdata_q   <= '0;
      req_taken <= 1'b0;
    end else begin
      cyc_q     <= cyc_nx;
      addr_q    <= addr_nx;
      wide_q    <= wide_nx;
      wdata_q   <= wdata_nx;
      req_taken <= wrap && (data_req || code_req);
    end
  end
endmodule

// File: rtl/bseq_strobes.sv
module bseq_strobes
  import bseq_pkg::*;
#(
  parameter  int STATES = 6,
  localparam int IW     = $clog2(STATES) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  cyc_e          cyc_nx,
  input  logic [IW-1:0] idx_nx,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          psen_n_nx,
  output logic          rd_n_nx
);
  localparam logic [IW-1:0] HALF_I = IW'(STATES);
  localparam logic [IW-1:0] ALE_I  = IW'(ALE_TICKS);
  localparam logic [IW-1:0] ADR_I  = IW'(ADDR_TICKS);
  localparam logic [IW-1:0] DEND_I = IW'(2 * STATES - 2);

  logic          second;
  logic [IW-1:0] rel;
  logic          is_data;
  logic          ale_nx;
  logic          wr_n_nx;
  logic          mid;

  always_comb begin
    second    = idx_nx >= HALF_I;
    rel       = second ? idx_nx - HALF_I : idx_nx;
    is_data   = (cyc_nx == CY_DRD) || (cyc_nx == CY_DWR);
    mid       = (idx_nx >= ADR_I) && (idx_nx <= DEND_I);
    ale_nx    = (rel < ALE_I) && !(second && is_data);
    psen_n_nx = !((cyc_nx == CY_CODE) && (rel >= ADR_I));
    rd_n_nx   = !((cyc_nx == CY_DRD) && mid);
    wr_n_nx   = !((cyc_nx == CY_DWR) && mid);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= 1'b1;
      psen_n <= 1'b1;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
    end else begin
      ale    <= ale_nx;
      psen_n <= psen_n_nx;
      rd_n   <= rd_n_nx;
      wr_n   <= wr_n_nx;
    end
  end
endmodule

// File: rtl/bseq_port_mux.sv
module bseq_port_mux
  import bseq_pkg::*;
#(
  parameter  int STATES = 6,
  parameter  int DW     = 8,
  localparam int AW     = 2 * DW,
  localparam int IW     = $clog2(STATES) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  cyc_e          cyc_nx,
  input  logic [IW-1:0] idx_nx,
  input  logic [AW-1:0] addr_nx,
  input  logic          wide_nx,
  input  logic [DW-1:0] wdata_nx,
  input  logic [DW-1:0] p0_sfr,
  input  logic [DW-1:0] p2_sfr,
  input  logic [DW-1:0] p0_in,
  input  logic          psen_n_q,
  input  logic          psen_n_nx,
  input  logic          rd_n_q,
  input  logic          rd_n_nx,
  output logic [DW-1:0] p0_out,
  output logic [DW-1:0] p0_oe,
  output logic [DW-1:0] p2_out,
  output logic          p2_oe,
  output logic [DW-1:0] code_byte,
  output logic          code_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam logic [IW-1:0] HALF_I = IW'(STATES);
  localparam logic [IW-1:0] ADR_I  = IW'(ADDR_TICKS);

  logic          second;
  logic [IW-1:0] rel;
  logic [AW-1:0] fa;
  logic [DW-1:0] p0_d, oe_d, p2_d;

  always_comb begin
    second = idx_nx >= HALF_I;
    rel    = second ? idx_nx - HALF_I : idx_nx;
    fa     = second ? addr_nx + AW'(1) : addr_nx;
    p0_d   = p0_sfr;
    oe_d   = ~p0_sfr;
    p2_d   = p2_sfr;
    unique case (cyc_nx)
      CY_CODE: begin
        p2_d = fa[AW-1:DW];
        p0_d = (rel < ADR_I) ? fa[DW-1:0] : '1;
        oe_d = (rel < ADR_I) ? '1 : '0;
      end
      CY_DRD, CY_DWR: begin
        p2_d = wide_nx ? addr_nx[AW-1:DW] : p2_sfr;
        if (idx_nx < ADR_I) begin
          p0_d = addr_nx[DW-1:0];
          oe_d = '1;
        end else if (cyc_nx == CY_DWR) begin
          p0_d = wdata_nx;
          oe_d = '1;
        end else begin
          p0_d = '1;
          oe_d = '0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p0_out     <= '1;
      p0_oe      <= '0;
      p2_out     <= '1;
      p2_oe      <= 1'b0;
      code_byte  <= '0;
      code_valid <= 1'b0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      p0_out     <= p0_d;
      p0_oe      <= oe_d;
      p2_out     <= p2_d;
      p2_oe      <= 1'b1;
      code_valid <= !psen_n_q && psen_n_nx;
      rd_valid   <= !rd_n_q && rd_n_nx;
      if (!psen_n_q && psen_n_nx) code_byte <= p0_in;
      if (!rd_n_q && rd_n_nx)     rd_data   <= p0_in;
    end
  end
endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
  import bseq_pkg::*;
#(
  parameter  int STATES = 6,
  parameter  int DW     = 8,
  localparam int AW     = 2 * DW,
  localparam int IW     = $clog2(STATES) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          code_req,
  input  logic [AW-1:0] code_addr,
  input  logic          data_req,
  input  logic          data_wr,
  input  logic          data_wide,
  input  logic [AW-1:0] data_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] p0_sfr,
  input  logic [DW-1:0] p2_sfr,
  input  logic [DW-1:0] p0_in,
  output logic          req_taken,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] p0_out,
  output logic [DW-1:0] p0_oe,
  output logic [DW-1:0] p2_out,
  output logic          p2_oe,
  output logic [DW-1:0] code_byte,
  output logic          code_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [IW-1:0] idx_nx;
  logic          wrap;
  cyc_e          cyc_nx;
  logic [AW-1:0] addr_nx;
  logic          wide_nx;
  logic [DW-1:0] wdata_nx;
  logic          psen_n_nx, rd_n_nx;

  bseq_timebase #(.STATES(STATES)) u_tb (
    .clk(clk), .rst(rst), .idx_nx(idx_nx), .wrap(wrap)
  );

  bseq_cycle_ctl #(.AW(AW), .DW(DW)) u_ctl (
    .clk(clk), .rst(rst), .wrap(wrap),
    .code_req(code_req), .code_addr(code_addr),
    .data_req(data_req), .data_wr(data_wr), .data_wide(data_wide),
    .data_addr(data_addr), .wr_data(wr_data),
    .cyc_nx(cyc_nx), .addr_nx(addr_nx), .wide_nx(wide_nx),
    .wdata_nx(wdata_nx), .req_taken(req_taken)
  );

  bseq_strobes #(.STATES(STATES)) u_stb (
    .clk(clk), .rst(rst), .cyc_nx(cyc_nx), .idx_nx(idx_nx),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .psen_n_nx(psen_n_nx), .rd_n_nx(rd_n_nx)
  );

  bseq_port_mux #(.STATES(STATES), .DW(DW)) u_mux (
    .clk(clk), .rst(rst), .cyc_nx(cyc_nx), .idx_nx(idx_nx),
    .addr_nx(addr_nx), .wide_nx(wide_nx), .wdata_nx(wdata_nx),
    .p0_sfr(p0_sfr), .p2_sfr(p2_sfr), .p0_in(p0_in),
    .psen_n_q(psen_n), .psen_n_nx(psen_n_nx),
    .rd_n_q(rd_n), .rd_n_nx(rd_n_nx),
    .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out), .p2_oe(p2_oe),
    .code_byte(code_byte), .code_valid(code_valid),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ale,
  input logic          psen_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic [DW-1:0] p0_out,
  input logic [DW-1:0] p0_oe,
  input logic          code_valid,
  input logic          rd_valid
);
  AST_ALE_TWO_WIDE: assert property (@(posedge clk) disable iff (rst) $rose(ale) |=> ale); // R1
  AST_CODE_ON_RISE: assert property (@(posedge clk) disable iff (rst) code_valid |-> $rose(psen_n)); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) $countones({~psen_n, ~rd_n, ~wr_n}) <= 1); // R4
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (rst) ale |-> (psen_n && rd_n && wr_n)); // R5
  AST_RD_ON_RISE: assert property (@(posedge clk) disable iff (rst) rd_valid |-> $rose(rd_n)); // R7
  AST_WR_DATA_HELD: assert property (@(posedge clk) disable iff (rst) (!wr_n && !$past(wr_n)) |-> $stable(p0_out)); // R8
  AST_FLOAT_ON_READ: assert property (@(posedge clk) disable iff (rst) (!psen_n || !rd_n) |-> (p0_oe == '0)); // R9
  AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst) !wr_n |-> (&p0_oe)); // R9
endmodule

bind bus_strobe_seq bseq_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
  .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe),
  .code_valid(code_valid), .rd_valid(rd_valid)
);

// File: tb/sim_bus_strobe_seq.sv
module sim_bus_strobe_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        code_req = 1'b0, data_req = 1'b0, data_wr = 1'b0, data_wide = 1'b0;
  logic [15:0] code_addr = '0, data_addr = '0;
  logic [7:0]  wr_data = '0, p0_sfr = 8'hFF, p2_sfr = 8'hFF;
  logic [7:0]  p0_in;
  logic        req_taken, ale, psen_n, rd_n, wr_n, p2_oe, code_valid, rd_valid;
  logic [7:0]  p0_out, p0_oe, p2_out, code_byte, rd_data;

  int vectors = 0, errors = 0, clk_cnt = 0;

  bus_strobe_seq u0 (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] code_fn(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] data_fn(logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h11;
  endfunction

  // external memory model, addressed by the byte latched at ALE fall
  logic [15:0] cur_lat = '0;
  assign p0_in = !psen_n ? code_fn(cur_lat) : (!rd_n ? data_fn(cur_lat) : 8'hFF);

  // monitor
  logic ale_p = 1'b1, psen_p = 1'b1, rd_p = 1'b1, wr_p = 1'b1;
  int n_ale, ale_run, ale_w, n_lat, n_psen, psen_run, psen_w, n_rd, rd_run, rd_w;
  int n_wr, wr_run, wr_w, wr_bad, float_bad, n_cb, n_rdv;
  logic [15:0] lat [4];
  logic [7:0]  lat_oe, wr_val, rdv;
  logic [7:0]  cb [4];

  task automatic clear_mon();
    n_ale = 0; n_lat = 0; n_psen = 0; n_rd = 0; n_wr = 0;
    wr_bad = 0; float_bad = 0; n_cb = 0; n_rdv = 0;
    ale_w = 0; psen_w = 0; rd_w = 0; wr_w = 0;
    psen_run = 0; rd_run = 0; wr_run = 0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (ale) begin
        if (!ale_p) begin n_ale++; ale_run = 0; end
        ale_run++;
      end else if (ale_p) begin
        ale_w = ale_run;
        cur_lat = {p2_out, p0_out};
        if (n_lat < 4) lat[n_lat] = cur_lat;
        lat_oe = p0_oe;
        n_lat++;
      end
      if (!psen_n) begin
        if (psen_p) n_psen++;
        psen_run++;
        if (p0_oe != 8'h00) float_bad++;
      end else if (!psen_p) begin psen_w = psen_run; psen_run = 0; end
      if (!rd_n) begin
        if (rd_p) n_rd++;
        rd_run++;
        if (p0_oe != 8'h00) float_bad++;
      end else if (!rd_p) begin rd_w = rd_run; rd_run = 0; end
      if (!wr_n) begin
        if (wr_p) begin n_wr++; wr_val = p0_out; end
        else if (p0_out != wr_val) wr_bad++;
        if (p0_oe != 8'hFF) wr_bad++;
        wr_run++;
      end else if (!wr_p) begin wr_w = wr_run; wr_run = 0; end
      if (code_valid) begin
        if (n_cb < 4) cb[n_cb] = code_byte;
        n_cb++;
      end
      if (rd_valid) begin rdv = rd_data; n_rdv++; end
    end
    ale_p = ale; psen_p = psen_n; rd_p = rd_n; wr_p = wr_n;
  end

  task automatic chk(string req, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wait_taken();
    do tick(1); while (!req_taken);
  endtask

  // run one accepted request and observe the following 12 periods
  task automatic run_req(logic code, logic data, logic wr, logic wide,
                         logic [15:0] ca, logic [15:0] da, logic [7:0] wd);
    code_req = code; data_req = data; data_wr = wr; data_wide = wide;
    code_addr = ca; data_addr = da; wr_data = wd;
    wait_taken();
    code_req = 1'b0; data_req = 1'b0;
    clear_mon();
    tick(12);
  endtask

  task automatic t_reset();
    tick(1);
    chk("R12", "ale", ale, 1);
    chk("R12", "strobes", {psen_n, rd_n, wr_n}, 3'b111);
    chk("R12", "p0_oe", p0_oe, 0);
    chk("R12", "p2_oe", p2_oe, 0);
    chk("R12", "req_taken", req_taken, 0);
  endtask

  task automatic t_idle();
    p0_sfr = 8'hA5;
    tick(12);
    clear_mon();
    tick(24);
    chk("R1", "idle ale rises in 24", n_ale, 4);
    chk("R1", "ale width", ale_w, 2);
    chk("R4", "idle psen pulses", n_psen, 0);
    chk("R10", "idle p0_out", p0_out, 8'hA5);
    chk("R10", "idle p0_oe", p0_oe, 8'h5A);
    chk("R12", "p2_oe after reset", p2_oe, 1);
    p0_sfr = 8'hFF;
  endtask

  task automatic t_code(logic [15:0] a);
    run_req(1'b1, 1'b0, 1'b0, 1'b0, a, 16'h0, 8'h0);
    chk("R1", "code ale rises", n_ale, 2);
    chk("R3", "code psen pulses", n_psen, 2);
    chk("R3", "psen width", psen_w, 3);
    chk("R5", "first fetch addr", lat[0], a);
    chk("R6", "second fetch addr", lat[1], a + 16'd1);
    chk("R3", "code bytes", n_cb, 2);
    chk("R3", "byte 0", cb[0], code_fn(a));
    chk("R3", "byte 1", cb[1], code_fn(a + 16'd1));
    chk("R9", "float during psen", float_bad, 0);
  endtask

  task automatic t_read(logic wide, logic [15:0] a, logic [15:0] exp_a);
    run_req(1'b0, 1'b1, 1'b0, wide, 16'h0, a, 8'h0);
    chk("R2", "data ale rises", n_ale, 1);
    chk("R4", "data psen pulses", n_psen, 0);
    chk("R7", "rd pulses", n_rd, 1);
    chk("R7", "rd width", rd_w, 8);
    chk("R6", "read latched addr", lat[0], exp_a);
    chk("R9", "addr drive oe", lat_oe, 8'hFF);
    chk("R7", "rd_valid count", n_rdv, 1);
    chk("R7", "rd_data", rdv, data_fn(exp_a));
    chk("R9", "float during rd", float_bad, 0);
  endtask

  task automatic t_write(logic [15:0] a, logic [7:0] d);
    run_req(1'b0, 1'b1, 1'b1, 1'b1, 16'h0, a, d);
    chk("R2", "write ale rises", n_ale, 1);
    chk("R4", "write psen pulses", n_psen, 0);
    chk("R8", "wr pulses", n_wr, 1);
    chk("R8", "wr width", wr_w, 8);
    chk("R8", "wr value", wr_val, d);
    chk("R8", "wr stable and driven", wr_bad, 0);
    chk("R5", "write latched addr", lat[0], a);
  endtask

  task automatic t_priority();
    code_req = 1'b1; code_addr = 16'h4410;
    data_req = 1'b1; data_wr = 1'b0; data_wide = 1'b1; data_addr = 16'h0055;
    wait_taken();
    data_req = 1'b0;
    clear_mon();
    tick(11);
    chk("R11", "data first: rd", n_rd, 1);
    chk("R11", "data first: psen", n_psen, 0);
    wait_taken();
    code_req = 1'b0;
    clear_mon();
    tick(12);
    chk("R11", "code next: psen", n_psen, 2);
    chk("R11", "code next: addr", lat[0], 16'h4410);
  endtask

  always @(posedge clk) begin
    clk_cnt++;
    if (clk_cnt > 50000) begin
      errors++;
      $display("FAIL watchdog: got %0d expected <= 50000 cycles", clk_cnt);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    t_reset();
    rst = 1'b0;
    t_idle();
    t_code(16'h3480);
    t_code(16'h12FF);
    t_read(1'b1, 16'hBEFF, 16'hBEFF);
    p2_sfr = 8'h77;
    t_read(1'b0, 16'hBE42, 16'h7742);
    p2_sfr = 8'hFF;
    t_write(16'h0310, 8'hC3);
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule